// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Sticky Error Status

This block turns an asynchronous serial line into parallel characters of 7, 8 or 9 bits. It runs on a sample strobe at sixteen times the bit rate. A falling edge on the idle line starts a frame, and that start bit must still be low at mid-bit for the frame to go on. The data bits arrive least significant first. An optional parity bit follows, then one or two stop bits. When the first stop bit has been sampled, the assembled character goes into a 9-bit holding register and a one-cycle completion interrupt is raised. The shift register that assembles the character cannot be seen from outside.

Three error flags report the last completed frame: parity mismatch, framing (a low first stop bit) and overrun (a frame completed while the previous character was still unread). They hold until the holding register is read or the next frame completes. A following frame with the same error keeps the flag set, and a clean following frame clears it. A fourth status bit tracks a companion transmitter. Its start strobe sets the bit and its end strobe clears it. Baud-rate generation and the transmit datapath live elsewhere.

Top module: `uart_rx_status`

## Requirements
- R1: After reset, `rx_data` is 0, all four `status` bits are 0 and `rx_done_irq` is 0.
- R2: The length code in `cfg_len` selects the character size: 00 gives 7 bits, 01 gives 8, 10 gives 9, and 11 is treated as 8. Bits are received least significant first and placed in the low bits of `rx_data`, with every unused upper bit stored as 0.
- R3: The parity code in `cfg_parity` selects the parity rule. 00 means there is no parity bit. 01 means the parity bit must be 0. 10 means odd parity over data plus parity bit, and 11 means even. A mismatch sets `status[2]`.
- R4: A low first stop bit sets `status[1]`. When `cfg_stop2` is 1, the second stop bit is waited out but never checked.
- R5: A start bit counts only if the line is still low on the 8th sample strobe after the falling edge. Otherwise it is discarded with no transfer and no interrupt, and the next proper frame is received normally.
- R6: Each completed frame raises `rx_done_irq` for exactly one clock, and `rx_data` already holds the new character in that cycle.
- R7: While `rx_enable` is 0, no frame is transferred, no interrupt is raised and `rx_data` keeps its value.
- R8: If a frame completes while the previous character is unread and `buf_rd` is not high in that cycle, `status[0]` is set and the new character overwrites `rx_data`.
- R9: A `buf_rd` pulse, with no frame completing in that cycle, clears `status[2:0]`.
- R10: Each completed frame rewrites the error flags. A flag stays set if the new frame has the same error, and is cleared if it does not.
- R11: When `buf_rd` and the completion of a frame with an error fall in the same cycle, the error flag ends up set.
- R12: `status[3]` is set by `tx_start` and cleared by `tx_end`. If both arrive in the same cycle, it ends up set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_serial | input | 1 | Asynchronous serial input, idle high |
| sample_en | input | 1 | One-cycle strobe at 16x the bit rate |
| cfg_len | input | 2 | Character length code |
| cfg_parity | input | 2 | Parity rule code |
| cfg_stop2 | input | 1 | 1 selects two stop bits |
| rx_enable | input | 1 | Reception enable |
| buf_rd | input | 1 | Read strobe for the holding register |
| tx_start | input | 1 | Transmitter start strobe |
| tx_end | input | 1 | Transmitter end strobe |
| rx_data | output | 9 | Received character, zero-filled above its length |
| status | output | 4 | [3] tx busy, [2] parity, [1] framing, [0] overrun |
| rx_done_irq | output | 1 | One-cycle reception-complete pulse |

## Verification
The bench sends a 7-bit character with all bits set. A receiver that does not zero-fill would show stray high bits, and one with the wrong shift alignment would show a shifted value. A second frame that repeats a parity error, followed by a clean one, catches flags that are not sticky or that never clear. The bench holds the read strobe high across a frame's completion, which exposes a read that wins over a new error. A low second stop bit, a short start glitch, length code 11 and a frame sent while reception is disabled each show up directly at the ports as a wrong flag, a spurious interrupt or a changed character.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  typedef enum logic [1:0] {
    PAR_NONE = 2'b00,
    PAR_ZERO = 2'b01,
    PAR_ODD  = 2'b10,
    PAR_EVEN = 2'b11
  } par_mode_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP1,
    ST_STOP2
  } rx_state_t;

  typedef struct packed {
    logic [8:0] data;
    logic       par_err;
    logic       frm_err;
  } rx_frame_t;

  // number of data bits for a length code
  function automatic logic [3:0] char_bits(input logic [1:0] len);
    case (len)
      2'b00:   return 4'd7;
      2'b10:   return 4'd9;
      default: return 4'd8;
    endcase
  endfunction

  // bits enter at the top of the shift register, so a short character sits high
  function automatic logic [8:0] align_char(input logic [8:0] sh, input logic [3:0] n);
    return sh >> (4'd9 - n);
  endfunction

  // 1 when the received parity bit disagrees with the selected rule
  function automatic logic parity_bad(input logic [8:0] d, input logic p, input par_mode_t m);
    case (m)
      PAR_ZERO: return p;
      PAR_ODD:  return ~(^d ^ p);
      PAR_EVEN: return ^d ^ p;
      default:  return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic sync_out
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (!rst_n) chain <= '1;
    else        chain <= {chain[STAGES-2:0], async_in};
  end

  assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
  import uart_rx_pkg::*;
#(
  parameter int OVERSAMPLE = 16
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      line,
  input  logic      tick,
  input  logic      enable,
  input  logic [1:0] cfg_len,
  input  logic [1:0] cfg_parity,
  input  logic      cfg_stop2,
  output logic      done,
  output rx_frame_t frame
);
  localparam int CW  = $clog2(OVERSAMPLE);
  localparam int MID = OVERSAMPLE / 2;
  localparam logic [CW-1:0] MID_LAST = CW'(MID - 1);
  localparam logic [CW-1:0] BIT_LAST = CW'(OVERSAMPLE - 1);

  rx_state_t       state;
  logic [CW-1:0]   tick_cnt;
  logic [3:0]      bit_idx;
  logic [8:0]      shreg;
  logic            line_prev;
  logic            par_bit;
  logic [3:0]      nbits;
  par_mode_t       pmode;
  logic [8:0]      char_now;

  // named internal events
  logic start_edge;
  logic start_glitch;
  logic bit_point;

  assign nbits        = char_bits(cfg_len);
  assign pmode        = par_mode_t'(cfg_parity);
  assign char_now     = align_char(shreg, nbits);
  assign start_edge   = tick && state == ST_IDLE && line_prev && !line;
  assign start_glitch = tick && state == ST_START && tick_cnt == MID_LAST && line;
  assign bit_point    = tick && tick_cnt == BIT_LAST;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      tick_cnt  <= '0;
      bit_idx   <= '0;
      shreg     <= '0;
      line_prev <= 1'b1;
      par_bit   <= 1'b0;
      done      <= 1'b0;
      frame     <= '0;
    end else begin
      done <= 1'b0;
      if (tick) line_prev <= line;
      if (!enable) begin
        state    <= ST_IDLE;
        tick_cnt <= '0;
      end else if (tick) begin
        case (state)
          ST_IDLE: begin
            if (start_edge) begin
              state    <= ST_START;
              tick_cnt <= '0;
            end
          end
          ST_START: begin
            if (tick_cnt == MID_LAST) begin
              tick_cnt <= '0;
              bit_idx  <= '0;
              state    <= line ? ST_IDLE : ST_DATA;
            end else begin
              tick_cnt <= tick_cnt + 1'b1;
            end
          end
          ST_DATA: begin
            if (bit_point) begin
              tick_cnt <= '0;
              shreg    <= {line, shreg[8:1]};
              if (bit_idx == nbits - 4'd1)
                state <= (pmode == PAR_NONE) ? ST_STOP1 : ST_PAR;
              else
                bit_idx <= bit_idx + 4'd1;
            end else begin
              tick_cnt <= tick_cnt + 1'b1;
            end
          end
          ST_PAR: begin
            if (bit_point) begin
              tick_cnt <= '0;
              par_bit  <= line;
              state    <= ST_STOP1;
            end else begin
              tick_cnt <= tick_cnt + 1'b1;
            end
          end
          ST_STOP1: begin
            if (bit_point) begin
              tick_cnt      <= '0;
              done          <= 1'b1;
              frame.data    <= char_now;
              frame.par_err <= parity_bad(char_now, par_bit, pmode);
              frame.frm_err <= !line;
              state         <= cfg_stop2 ? ST_STOP2 : ST_IDLE;
            end else begin
              tick_cnt <= tick_cnt + 1'b1;
            end
          end
          ST_STOP2: begin
            if (bit_point) begin
              tick_cnt <= '0;
              state    <= ST_IDLE;
            end else begin
              tick_cnt <= tick_cnt + 1'b1;
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  // R5
  glitch_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_glitch && enable |=> state == ST_IDLE && !done);

  // R7
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !done);

  // R4
  stop2_no_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_STOP2 |-> !done || $past(state) == ST_STOP1);
endmodule

// File: rtl/uart_rx_store.sv
module uart_rx_store
  import uart_rx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       done,
  input  rx_frame_t  frame,
  input  logic       buf_rd,
  input  logic       tx_start,
  input  logic       tx_end,
  output logic [8:0] buf_data,
  output logic       err_par,
  output logic       err_frm,
  output logic       err_ovr,
  output logic       tx_busy,
  output logic       irq
);
  logic full;
  logic overrun_now;

  assign overrun_now = done && full && !buf_rd;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      buf_data <= '0;
      full     <= 1'b0;
      err_par  <= 1'b0;
      err_frm  <= 1'b0;
      err_ovr  <= 1'b0;
      irq      <= 1'b0;
    end else begin
      irq <= done;
      if (done) begin
        buf_data <= frame.data;
        full     <= 1'b1;
        err_par  <= frame.par_err;
        err_frm  <= frame.frm_err;
        err_ovr  <= overrun_now;
      end else if (buf_rd) begin
        full    <= 1'b0;
        err_par <= 1'b0;
        err_frm <= 1'b0;
        err_ovr <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        tx_busy <= 1'b0;
    else if (tx_start) tx_busy <= 1'b1;
    else if (tx_end)   tx_busy <= 1'b0;
  end

  // R11
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && buf_rd && frame.par_err |=> err_par);

  // R9
  read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    buf_rd && !done |=> !err_par && !err_frm && !err_ovr);

  // R8
  overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && full && !buf_rd |=> err_ovr);

  // R6
  irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  // R12
  tx_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |=> tx_busy);
endmodule

// File: rtl/uart_rx_status.sv
module uart_rx_status
  import uart_rx_pkg::*;
#(
  parameter int OVERSAMPLE  = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_serial,
  input  logic       sample_en,
  input  logic [1:0] cfg_len,
  input  logic [1:0] cfg_parity,
  input  logic       cfg_stop2,
  input  logic       rx_enable,
  input  logic       buf_rd,
  input  logic       tx_start,
  input  logic       tx_end,
  output logic [8:0] rx_data,
  output logic [3:0] status,
  output logic       rx_done_irq
);
  logic      line_s;
  logic      frame_done;
  rx_frame_t frame;
  logic      e_par, e_frm, e_ovr, busy;

  uart_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(rx_serial), .sync_out(line_s)
  );

  uart_rx_frame #(.OVERSAMPLE(OVERSAMPLE)) u_frame (
    .clk(clk), .rst_n(rst_n), .line(line_s), .tick(sample_en),
    .enable(rx_enable), .cfg_len(cfg_len), .cfg_parity(cfg_parity),
    .cfg_stop2(cfg_stop2), .done(frame_done), .frame(frame)
  );

  uart_rx_store u_store (
    .clk(clk), .rst_n(rst_n), .done(frame_done), .frame(frame),
    .buf_rd(buf_rd), .tx_start(tx_start), .tx_end(tx_end),
    .buf_data(rx_data), .err_par(e_par), .err_frm(e_frm), .err_ovr(e_ovr),
    .tx_busy(busy), .irq(rx_done_irq)
  );

  assign status = {busy, e_par, e_frm, e_ovr};

  // R2
  zero_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done_irq && cfg_len == 2'b00 |-> rx_data[8:7] == 2'b00);
endmodule

// File: tb/test_uart_rx_status.sv
module test_uart_rx_status;
  localparam int TDIV = 4;
  localparam int BITCLK = 16 * TDIV;

  logic clk = 0, rst_n = 0;
  logic rx_serial = 1, sample_en = 0;
  logic [1:0] cfg_len = 2'b01, cfg_parity = 2'b00;
  logic cfg_stop2 = 0, rx_enable = 1, buf_rd = 0, tx_start = 0, tx_end = 0;
  logic [8:0] rx_data;
  logic [3:0] status;
  logic rx_done_irq;

  int n_chk = 0, n_fail = 0, irq_cnt = 0;

  always #4 clk = ~clk;

  uart_rx_status i_uart_rx_status (
    .clk(clk), .rst_n(rst_n), .rx_serial(rx_serial), .sample_en(sample_en),
    .cfg_len(cfg_len), .cfg_parity(cfg_parity), .cfg_stop2(cfg_stop2),
    .rx_enable(rx_enable), .buf_rd(buf_rd), .tx_start(tx_start), .tx_end(tx_end),
    .rx_data(rx_data), .status(status), .rx_done_irq(rx_done_irq)
  );

  initial begin
    forever begin
      repeat (TDIV - 1) @(negedge clk);
      sample_en = 1;
      @(negedge clk);
      sample_en = 0;
    end
  end

  always @(posedge clk) if (rst_n && rx_done_irq) irq_cnt <= irq_cnt + 1;

  typedef struct packed {
    logic [1:0] len;
    logic [1:0] par;
    logic       stop2;
    logic [8:0] data;
    logic       bad_par;
    logic       bad_stop;
    logic [8:0] exp_data;
    logic       exp_pe;
    logic       exp_fe;
  } vec_t;

  localparam vec_t VEC [11] = '{
    '{2'b01, 2'b00, 1'b0, 9'h0A5, 1'b0, 1'b0, 9'h0A5, 1'b0, 1'b0},
    '{2'b00, 2'b00, 1'b0, 9'h1FF, 1'b0, 1'b0, 9'h07F, 1'b0, 1'b0},
    '{2'b10, 2'b11, 1'b0, 9'h155, 1'b0, 1'b0, 9'h155, 1'b0, 1'b0},
    '{2'b01, 2'b10, 1'b0, 9'h03C, 1'b0, 1'b0, 9'h03C, 1'b0, 1'b0},
    '{2'b01, 2'b11, 1'b0, 9'h0F0, 1'b1, 1'b0, 9'h0F0, 1'b1, 1'b0},
    '{2'b01, 2'b01, 1'b0, 9'h081, 1'b0, 1'b0, 9'h081, 1'b0, 1'b0},
    '{2'b01, 2'b01, 1'b0, 9'h081, 1'b1, 1'b0, 9'h081, 1'b1, 1'b0},
    '{2'b01, 2'b00, 1'b0, 9'h05A, 1'b0, 1'b1, 9'h05A, 1'b0, 1'b1},
    '{2'b00, 2'b10, 1'b1, 9'h055, 1'b0, 1'b0, 9'h055, 1'b0, 1'b0},
    '{2'b10, 2'b10, 1'b1, 9'h1C3, 1'b1, 1'b0, 9'h1C3, 1'b1, 1'b0},
    '{2'b11, 2'b00, 1'b0, 9'h1A5, 1'b0, 1'b0, 9'h0A5, 1'b0, 1'b0}
  };

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int width_of(input logic [1:0] len);
    return (len == 2'b00) ? 7 : (len == 2'b10) ? 9 : 8;
  endfunction

  task automatic drive_bit(input logic v);
    rx_serial = v;
    repeat (BITCLK) @(negedge clk);
  endtask

  task automatic send_frame(input logic [1:0] len, input logic [1:0] par, input logic stop2,
                            input logic [8:0] data, input logic bad_par, input logic bad_stop,
                            input logic bad_stop2);
    int n;
    logic ones;
    n = width_of(len);
    cfg_len = len; cfg_parity = par; cfg_stop2 = stop2;
    ones = 0;
    drive_bit(0);
    for (int i = 0; i < n; i++) begin
      ones = ones ^ data[i];
      drive_bit(data[i]);
    end
    if (par != 2'b00) begin
      logic pb;
      pb = (par == 2'b01) ? 1'b0 : (par == 2'b10) ? ~ones : ones;
      drive_bit(pb ^ bad_par);
    end
    drive_bit(~bad_stop);
    if (stop2) drive_bit(~bad_stop2);
    drive_bit(1);
    drive_bit(1);
  endtask

  task automatic read_buf();
    @(negedge clk); buf_rd = 1;
    @(negedge clk); buf_rd = 0;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int base;
    logic [8:0] held;
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    // R1
    chk("R1 data", rx_data, 0);
    chk("R1 status", status, 0);
    chk("R1 irq", rx_done_irq, 0);

    // table-driven frames: R2 R3 R4 R6 R9
    foreach (VEC[k]) begin
      base = irq_cnt;
      send_frame(VEC[k].len, VEC[k].par, VEC[k].stop2, VEC[k].data,
                 VEC[k].bad_par, VEC[k].bad_stop, 1'b0);
      chk("R6 one irq", irq_cnt - base, 1);
      chk("R2 data", rx_data, VEC[k].exp_data);
      chk("R3 parity flag", status[2], VEC[k].exp_pe);
      chk("R4 framing flag", status[1], VEC[k].exp_fe);
      chk("R8 no overrun", status[0], 0);
      read_buf();
      chk("R9 read clears", status[2:0], 0);
    end

    // R4: second stop bit low is not checked
    send_frame(2'b01, 2'b00, 1'b1, 9'h033, 1'b0, 1'b0, 1'b1);
    chk("R4 second stop ignored", status[1], 0);
    chk("R4 data", rx_data, 9'h033);
    read_buf();

    // R5: start glitch shorter than half a bit
    base = irq_cnt;
    rx_serial = 0;
    repeat (3 * TDIV) @(negedge clk);
    rx_serial = 1;
    repeat (2 * BITCLK) @(negedge clk);
    chk("R5 glitch no irq", irq_cnt - base, 0);
    send_frame(2'b01, 2'b00, 1'b0, 9'h0C6, 1'b0, 1'b0, 1'b0);
    chk("R5 frame after glitch", rx_data, 9'h0C6);
    read_buf();

    // R7: disabled receiver
    held = rx_data;
    base = irq_cnt;
    rx_enable = 0;
    send_frame(2'b01, 2'b00, 1'b0, 9'h011, 1'b0, 1'b0, 1'b0);
    chk("R7 no irq", irq_cnt - base, 0);
    chk("R7 buffer kept", rx_data, held);
    rx_enable = 1;
    repeat (BITCLK) @(negedge clk);

    // R8 R10: unread buffer and sticky flags
    send_frame(2'b01, 2'b00, 1'b0, 9'h001, 1'b0, 1'b0, 1'b0);
    send_frame(2'b01, 2'b11, 1'b0, 9'h002, 1'b1, 1'b0, 1'b0);
    chk("R8 overrun set", status[0], 1);
    chk("R8 overwrite", rx_data, 9'h002);
    chk("R10 parity set", status[2], 1);
    send_frame(2'b01, 2'b11, 1'b0, 9'h003, 1'b1, 1'b0, 1'b0);
    chk("R10 parity stays", status[2], 1);
    send_frame(2'b01, 2'b11, 1'b0, 9'h004, 1'b0, 1'b0, 1'b0);
    chk("R10 parity cleared by clean frame", status[2], 0);
    chk("R8 overrun again", status[0], 1);
    read_buf();
    chk("R9 all cleared", status[2:0], 0);

    // R11: read held across completion of an erroneous frame
    fork
      send_frame(2'b01, 2'b11, 1'b0, 9'h0AA, 1'b1, 1'b0, 1'b0);
      begin
        buf_rd = 1;
        do @(negedge clk); while (!rx_done_irq);
        buf_rd = 0;
      end
    join
    chk("R11 set wins", status[2], 1);
    chk("R11 no overrun", status[0], 0);
    read_buf();

    // R12: transmit busy flag
    @(negedge clk); tx_start = 1;
    @(negedge clk); tx_start = 0;
    chk("R12 busy set", status[3], 1);
    tx_end = 1;
    @(negedge clk); tx_end = 0;
    chk("R12 busy cleared", status[3], 0);
    tx_start = 1; tx_end = 1;
    @(negedge clk); tx_start = 0; tx_end = 0;
    chk("R12 start wins", status[3], 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule